// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address plus read, write and execute rights. It reads up to three 8-byte table entries from memory to do this. A requester presents one translation at a time: the address, a mask of the kinds of access it needs, and a 2-bit privilege mode. The walker answers with a single-cycle completion pulse. That pulse carries either the translated address and the granted rights, or a fault code and the address that faulted. Storing results, sharing the memory port and raising the exception are left to the surrounding logic.

Two cases finish without touching memory. A non-canonical address is rejected at once. A negative address tagged as a kernel superpage is mapped directly, with one address bit moved. Every other address goes through a root entry, a middle entry and a leaf entry. In the leaf, the rights are picked per mode by shifting the enable bits. They are then trimmed by fault-on-access bits that decide the fault code by priority.

Top module: `pgwalk3_top`

## Requirements
- R1: If any of bits 63:43 of the virtual address differs from bit 63, the block reports an access violation (code 1). It issues no memory read.
- R2: A kernel-mode request (mode 0) whose address has bit 63 set and bits 42:41 equal to 2'b10 succeeds with rights 3'b111 and no memory read. The physical address is bits 39:0 of the virtual address, with virtual bit 40 copied to physical bit 43 and all other bits zero.
- R3: The same superpage address requested in modes 1 to 3 gives an access violation (code 1) and no memory read.
- R4: The entry reads are at table base + 8 × index. The level-1 index is va[42:33], the level-2 index is va[32:23] and the level-3 index is va[22:13]. The first base is the `ptbr` input. Each later base is entry bits 63:32 shifted left by 13.
- R5: At level 1 or level 2, an entry with bit 0 (valid) clear ends the walk with translation-not-valid (code 2). A valid entry with bit 8 clear ends it with an access violation (code 1), whatever the mode.
- R6: A leaf entry with bit 0 clear gives translation-not-valid (code 2).
- R7: In the leaf, read and execute rights come from bit 8+mode and write rights from bit 12+mode. The access mask and the rights use bit 0 for read, bit 1 for write and bit 2 for execute. A non-zero mask with none of its accesses granted gives an access violation (code 1).
- R8: Leaf bits 1, 2 and 3 withdraw read, write and execute respectively. If a non-zero mask has none of its accesses left after that, the code is 5 when execute was asked for, else 4 when write was asked for, else 3.
- R9: A walk that ends without a fault reports code 0 and the rights left after R8. The address is leaf bits 63:32 shifted left by 13, OR-ed with va[12:0]. An empty access mask never faults in the leaf.
- R10: `req_ready` is high only when the block is idle. A memory request is held with a stable address until it is accepted. `done` lasts exactly one cycle and returns the requested address. On a fault it reports a zero address and zero rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 64 | Virtual address to translate |
| req_acc | input | 3 | Access mask: bit 0 read, bit 1 write, bit 2 execute |
| req_mode | input | 2 | Privilege mode, 0 is kernel |
| ptbr | input | 64 | Physical byte address of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Translation faulted |
| done_code | output | 3 | 0 none, 1 access violation, 2 not valid, 3 fault on read, 4 fault on write, 5 fault on execute |
| done_pa | output | 64 | Physical address, zero on fault |
| done_perm | output | 3 | Granted rights, zero on fault |
| done_va | output | 64 | Virtual address of the completed request |

## Verification
If the walk level counter or the table base is wrong, the next memory read goes to the wrong entry address. The bench memory answers such a read with an all-zero entry, so the request completes with code 2 instead of the expected result on that same request. If the mode shift or the fault-on mask is wrong, the rights or the fault code on the completion pulse are wrong; the sweep covers every mode, every access mask and all fault-on patterns, so the first bad combination shows it. If a shortcut path is wrong, memory reads appear where none should occur, and the bench counts reads for every request.

// File: rtl/pgwalk3_pkg.sv
// Package: shared codes, entry bit positions and walker state type.
// Assumes 64-bit entries, with permission and fault-on bits in the low 16 bits.
package pgwalk3_pkg;

    // Fault codes reported on completion
    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } flt_e;

    // Walker control states
    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_FIN
    } wst_e;

    // Entry bit positions (behaviour depends on these)
    localparam int unsigned ENT_VALID  = 0;
    localparam int unsigned ENT_NO_RD  = 1;
    localparam int unsigned ENT_RE_LO  = 8;
    localparam int unsigned ENT_WE_LO  = 12;

    // Superpage tag and remap positions
    localparam int unsigned SP_TAG_LO  = 41;
    localparam logic [1:0]  SP_TAG     = 2'b10;
    localparam int unsigned SP_SRC_BIT = 40;
    localparam int unsigned SP_DST_BIT = 43;

    localparam logic [1:0]  MODE_KERNEL = 2'd0;

endpackage

// File: rtl/pgwalk3_region.sv
// Region classifier: flags non-canonical addresses, detects the kernel
// superpage window and forms its direct-mapped physical address.
// Purely combinational; assumes VA_W is above the superpage tag bits.
module pgwalk3_region
    import pgwalk3_pkg::*;
#(
    parameter int unsigned VA_W = 43
) (
    input  logic [63:0] va,
    output logic        bad_canon,
    output logic        in_super,
    output logic [63:0] super_pa
);
    localparam int unsigned HI_W = 64 - VA_W;

    logic [HI_W-1:0] hi_bits;

    // Canonical test: upper bits all equal the sign
    always_comb begin
        hi_bits   = va[63:VA_W];
        bad_canon = !((&hi_bits) || !(|hi_bits));
    end

    // Superpage detection and bit-relocating direct map
    always_comb begin
        in_super = va[63] && (va[SP_TAG_LO+1:SP_TAG_LO] == SP_TAG);
        super_pa = '0;
        super_pa[SP_SRC_BIT-1:0] = va[SP_SRC_BIT-1:0];
        super_pa[SP_DST_BIT]     = va[SP_SRC_BIT];
    end
endmodule

// File: rtl/pgwalk3_slot.sv
// Entry address former: picks the index field for the current level and
// adds it, scaled by the entry size, to the current table base.
// Assumes LEVELS*IDX_W bits of index sit directly above the page offset.
module pgwalk3_slot #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned LEVELS = 3,
    parameter int unsigned LVL_W  = 2
) (
    input  logic [LEVELS*IDX_W-1:0] va_idx,
    input  logic [LVL_W-1:0]        lvl,
    input  logic [63:0]             base,
    output logic [63:0]             addr
);
    localparam int unsigned ENT_SH = 3;

    logic [IDX_W-1:0] idx_tab [LEVELS];
    logic [IDX_W-1:0] idx_sel;

    // One index field per level, root level taken from the top
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign idx_tab[g] = va_idx[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    // Select the field for the active level and scale to bytes
    always_comb begin
        idx_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) idx_sel = idx_tab[i];
        end
        addr = base + 64'({idx_sel, {ENT_SH{1'b0}}});
    end
endmodule

// File: rtl/pgwalk3_leaf.sv
// Leaf evaluator: derives rights for the current mode from the leaf entry,
// applies the fault-on mask and picks the fault code by priority.
// Assumes the leaf valid bit is handled by the caller.
module pgwalk3_leaf
    import pgwalk3_pkg::*;
(
    input  logic [15:0] ent_lo,
    input  logic [2:0]  acc,
    input  logic [1:0]  mode,
    output logic [2:0]  perm,
    output flt_e        code
);
    logic       re, we;
    logic [2:0] grant, kept, fo_mask;

    // Rights by mode shift, then mask and prioritised fault code
    always_comb begin
        re      = ent_lo[ENT_RE_LO + 32'(mode)];
        we      = ent_lo[ENT_WE_LO + 32'(mode)];
        grant   = {re, we, re};
        fo_mask = ent_lo[ENT_NO_RD +: 3];
        kept    = grant & ~fo_mask;
        perm    = kept;
        code    = FLT_NONE;
        if (acc != 3'b000 && (grant & acc) == 3'b000) begin
            code = FLT_ACV;
        end else if (acc != 3'b000 && (kept & acc) == 3'b000) begin
            if (acc[2])      code = FLT_FOE;
            else if (acc[1]) code = FLT_FOW;
            else             code = FLT_FOR;
        end
    end
endmodule

// File: rtl/pgwalk3_top.sv
// Three-level page table walker. Accepts one translation at a time,
// resolves the canonical and superpage shortcuts at once, otherwise reads
// root, middle and leaf entries and reports a result or fault on a
// one-cycle done pulse. Assumes memory returns one response per request.
module pgwalk3_top
    import pgwalk3_pkg::*;
#(
    parameter int unsigned VA_W   = 43,
    parameter int unsigned PG_OFF = 13,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned LEVELS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_va,
    input  logic [2:0]  req_acc,
    input  logic [1:0]  req_mode,
    input  logic [63:0] ptbr,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [63:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    output logic        done,
    output logic        done_fault,
    output logic [2:0]  done_code,
    output logic [63:0] done_pa,
    output logic [2:0]  done_perm,
    output logic [63:0] done_va
);
    localparam int unsigned SPAN  = LEVELS * IDX_W;
    localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(LEVELS - 1);

    wst_e             st;
    logic [LVL_W-1:0] lvl;
    logic [63:0]      base_q, va_q;
    logic [2:0]       acc_q;
    logic [1:0]       mode_q;

    logic             res_fault;
    flt_e             res_code;
    logic [63:0]      res_pa;
    logic [2:0]       res_perm;

    logic             bad_canon, in_super;
    logic [63:0]      super_pa;
    logic [2:0]       leaf_perm;
    flt_e             leaf_code;
    logic [63:0]      ent_frame;
    logic             ent_unused;

    logic             fin, descend;
    flt_e             f_code;
    logic [63:0]      f_pa;
    logic [2:0]       f_perm;

    pgwalk3_region #(.VA_W(VA_W)) region_i (
        .va        (req_va),
        .bad_canon (bad_canon),
        .in_super  (in_super),
        .super_pa  (super_pa)
    );

    pgwalk3_slot #(.IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) slot_i (
        .va_idx (va_q[PG_OFF +: SPAN]),
        .lvl    (lvl),
        .base   (base_q),
        .addr   (mem_req_addr)
    );

    pgwalk3_leaf leaf_i (
        .ent_lo (mem_rsp_data[15:0]),
        .acc    (acc_q),
        .mode   (mode_q),
        .perm   (leaf_perm),
        .code   (leaf_code)
    );

    // Frame or next table base from the upper half of an entry
    always_comb begin
        ent_frame  = 64'(mem_rsp_data[63:32]) << PG_OFF;
        ent_unused = ^mem_rsp_data[31:16];
    end

    // Decide whether this cycle ends the request, and with what result
    always_comb begin
        fin     = 1'b0;
        descend = 1'b0;
        f_code  = FLT_NONE;
        f_pa    = '0;
        f_perm  = '0;
        case (st)
            S_IDLE: begin
                if (req_valid) begin
                    if (bad_canon) begin
                        fin    = 1'b1;
                        f_code = FLT_ACV;
                    end else if (in_super) begin
                        fin = 1'b1;
                        if (req_mode == MODE_KERNEL) begin
                            f_pa   = super_pa;
                            f_perm = 3'b111;
                        end else begin
                            f_code = FLT_ACV;
                        end
                    end
                end
            end
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_data[ENT_VALID]) begin
                        fin    = 1'b1;
                        f_code = FLT_TNV;
                    end else if (lvl != LVL_LAST) begin
                        if (!mem_rsp_data[ENT_RE_LO]) begin
                            fin    = 1'b1;
                            f_code = FLT_ACV;
                        end else begin
                            descend = 1'b1;
                        end
                    end else begin
                        fin    = 1'b1;
                        f_code = leaf_code;
                        if (leaf_code == FLT_NONE) begin
                            f_pa   = ent_frame | 64'(va_q[PG_OFF-1:0]);
                            f_perm = leaf_perm;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    // Walker state, request capture, level advance and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            lvl       <= '0;
            base_q    <= '0;
            va_q      <= '0;
            acc_q     <= '0;
            mode_q    <= '0;
            res_fault <= 1'b0;
            res_code  <= FLT_NONE;
            res_pa    <= '0;
            res_perm  <= '0;
        end else begin
            if (fin) begin
                res_fault <= (f_code != FLT_NONE);
                res_code  <= f_code;
                res_pa    <= f_pa;
                res_perm  <= f_perm;
            end
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        acc_q  <= req_acc;
                        mode_q <= req_mode;
                        lvl    <= '0;
                        base_q <= ptbr;
                        st     <= fin ? S_FIN : S_REQ;
                    end
                end
                S_REQ: begin
                    if (mem_req_ready) st <= S_WAIT;
                end
                S_WAIT: begin
                    if (fin) begin
                        st <= S_FIN;
                    end else if (descend) begin
                        base_q <= ent_frame;
                        lvl    <= lvl + 1'b1;
                        st     <= S_REQ;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Port view of the controller and result registers
    always_comb begin
        req_ready     = (st == S_IDLE);
        mem_req_valid = (st == S_REQ);
        done          = (st == S_FIN);
        done_fault    = res_fault;
        done_code     = res_code;
        done_pa       = res_pa;
        done_perm     = res_perm;
        done_va       = va_q;
    end
endmodule

// File: rtl/pgwalk3_chk.sv
// Checker for the walker's port protocol and result shape, bound to the
// top module. Observes ports only.
module pgwalk3_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic        done,
    input logic        done_fault,
    input logic [2:0]  done_code,
    input logic [63:0] done_pa,
    input logic [2:0]  done_perm
);
    // R10: a stalled memory request keeps its address
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R4: every entry read is 8-byte aligned
    p_entry_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

    // R10: completion lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: no new request taken while busy
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || mem_req_valid) |-> !req_ready);

    // R10: faults carry zero address and zero rights
    p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault |-> done_pa == 64'd0 && done_perm == 3'b000);

    // R9: fault flag agrees with the code
    p_code_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_fault == (done_code != 3'd0)));
endmodule

bind pgwalk3_top pgwalk3_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .done_fault    (done_fault),
    .done_code     (done_code),
    .done_pa       (done_pa),
    .done_perm     (done_perm)
);

// File: tb/pgwalk3_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk3_top_tb_top;
    localparam logic [63:0] PTBR = 64'h0000_0000_0040_0000;
    localparam logic [31:0] L2F  = 32'h0000_0123;
    localparam logic [31:0] L3F  = 32'h0000_0456;
    localparam logic [31:0] LFR  = 32'h000A_BCDE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [2:0]  req_acc = '0;
    logic [1:0]  req_mode = '0;
    logic        mem_req_valid, mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, done_fault;
    logic [2:0]  done_code, done_perm;
    logic [63:0] done_pa, done_va;

    logic [15:0] l1_lo = 16'h0101, l2_lo = 16'h0101, leaf_lo = 16'h0001;
    logic [63:0] cur_va = '0;
    logic        stall_en = 1'b0;
    logic [31:0] cyc = 0, nreq = 0;
    int          checks = 0, errors = 0;

    always #10 clk = ~clk;

    pgwalk3_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_acc(req_acc), .req_mode(req_mode), .ptbr(PTBR),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
        .done_code(done_code), .done_pa(done_pa), .done_perm(done_perm),
        .done_va(done_va)
    );

    assign mem_req_ready = !stall_en || cyc[0];

    // Table contents: only the exact expected slot holds an entry (R4)
    function automatic logic [63:0] ent_at(input logic [63:0] a);
        if (a == PTBR + 64'({cur_va[42:33], 3'b000}))
            return {L2F, 16'h0, l1_lo};
        if (a == (64'(L2F) << 13) + 64'({cur_va[32:23], 3'b000}))
            return {L3F, 16'h0, l2_lo};
        if (a == (64'(L3F) << 13) + 64'({cur_va[22:13], 3'b000}))
            return {LFR, 16'h0, leaf_lo};
        return 64'd0;
    endfunction

    // Memory model: answers one cycle after acceptance, counts reads
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            nreq          <= 0;
        end else begin
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            mem_rsp_data  <= ent_at(mem_req_addr);
            if (mem_req_valid && mem_req_ready) nreq <= nreq + 1;
        end
    end

    task automatic check(input string tag, input logic [70:0] act, input logic [70:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected leaf outcome {fault, code, pa, perm} from R6..R9
    function automatic logic [70:0] exp_leaf(input logic [15:0] lo, input logic [2:0] acc,
                                             input logic [1:0] md, input logic [12:0] off);
        logic re, we;
        logic [2:0] g, k, c;
        re = lo[8 + 32'(md)];
        we = lo[12 + 32'(md)];
        g  = {re, we, re};
        if (!lo[0]) return {1'b1, 3'd2, 64'd0, 3'd0};
        if (acc != 0 && (g & acc) == 0) return {1'b1, 3'd1, 64'd0, 3'd0};
        k = g & ~lo[3:1];
        if (acc != 0 && (k & acc) == 0) begin
            c = acc[2] ? 3'd5 : (acc[1] ? 3'd4 : 3'd3);
            return {1'b1, c, 64'd0, 3'd0};
        end
        return {1'b0, 3'd0, (64'(LFR) << 13) | 64'(off), k};
    endfunction

    logic [70:0] res;
    logic [31:0] reads;

    task automatic xlat(input logic [63:0] va, input logic [2:0] acc, input logic [1:0] md);
        logic [31:0] n0;
        int w;
        cur_va = va;
        @(negedge clk);
        n0 = nreq;
        req_valid = 1'b1; req_va = va; req_acc = acc; req_mode = md;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!done && w < 100) begin @(negedge clk); w++; end
        if (!done) begin
            errors++;
            $display("FAIL R10 no completion actual=0 expected=1");
        end
        res   = {done_fault, done_code, done_pa, done_perm};
        reads = nreq - n0;
        check("R10 done_va", 71'(done_va), 71'(va));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] va;
        logic [15:0] lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 reset", 71'({req_ready, done, mem_req_valid}), 71'(3'b100));

        // R4 R7 R8 R9: sweep modes, access masks and leaf bit patterns
        for (int md = 0; md < 4; md++) begin
            stall_en = md[0];
            for (int acc = 0; acc < 8; acc++) begin
                for (int p = 0; p < 32; p++) begin
                    lo = 16'h0001 | 16'(p[4:2] << 1);
                    for (int m = 0; m < 4; m++) begin
                        lo[8 + m]  = (m == md) ? p[0] : !p[0];
                        lo[12 + m] = (m == md) ? p[1] : !p[1];
                    end
                    leaf_lo = lo;
                    va = {21'd0, 10'(acc * 97 + md * 301 + p), 10'(p * 33 + md),
                          10'(p * 19 + acc * 5 + 1), 13'(p * 251 + acc)};
                    xlat(va, 3'(acc), 2'(md));
                    check("R7 R8 R9 R4 leaf result", res, exp_leaf(lo, 3'(acc), 2'(md), va[12:0]));
                    check("R4 three reads", 71'(reads), 71'(3));
                end
            end
        end
        stall_en = 1'b0;

        // R4: negative canonical address outside superpage walks normally
        leaf_lo = 16'h1101;
        va = {21'h1FFFFF, 10'h3A5, 10'h155, 10'h2AA, 13'h1ABC};
        xlat(va, 3'b011, 2'd0);
        check("R4 negative walk", res, exp_leaf(16'h1101, 3'b011, 2'd0, 13'h1ABC));

        // R5: upper-level faults
        va = {21'd0, 10'h011, 10'h022, 10'h033, 13'h0044};
        l1_lo = 16'h0000; xlat(va, 3'b001, 2'd0);
        check("R5 L1 not valid", res, {1'b1, 3'd2, 64'd0, 3'd0});
        check("R5 L1 reads", 71'(reads), 71'(1));
        l1_lo = 16'h0001; xlat(va, 3'b001, 2'd0);
        check("R5 L1 no read enable", res, {1'b1, 3'd1, 64'd0, 3'd0});
        l1_lo = 16'h0101; l2_lo = 16'h0000; xlat(va, 3'b001, 2'd0);
        check("R5 L2 not valid", res, {1'b1, 3'd2, 64'd0, 3'd0});
        check("R5 L2 reads", 71'(reads), 71'(2));
        l2_lo = 16'h0201; xlat(va, 3'b001, 2'd1);
        check("R5 L2 kernel bit only", res, {1'b1, 3'd1, 64'd0, 3'd0});
        l2_lo = 16'h0101;

        // R6: leaf not valid even with all rights set
        leaf_lo = 16'hFF00; xlat(va, 3'b001, 2'd0);
        check("R6 leaf not valid", res, {1'b1, 3'd2, 64'd0, 3'd0});

        // R1: flip each upper bit of a canonical positive address
        for (int b = 43; b < 64; b++) begin
            va = 64'h0000_0123_4567_8000;
            va[b] = 1'b1;
            xlat(va, 3'b001, 2'd0);
            check("R1 non-canonical", res, {1'b1, 3'd1, 64'd0, 3'd0});
            check("R1 no reads", 71'(reads), 71'(0));
        end

        // R2 R3: superpage in each mode, both values of bit 40
        for (int s = 0; s < 2; s++) begin
            va = {21'h1FFFFF, 2'b10, 1'(s), 40'h12_3456_789A};
            for (int md = 0; md < 4; md++) begin
                xlat(va, 3'b111, 2'(md));
                if (md == 0)
                    check("R2 superpage", res,
                          {1'b0, 3'd0, {20'd0, 1'(s), 3'd0, 40'h12_3456_789A}, 3'b111});
                else
                    check("R3 superpage user", res, {1'b1, 3'd1, 64'd0, 3'd0});
                check("R2 R3 no reads", 71'(reads), 71'(0));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule